// File: doc/BRIEF.md
# Processor Status Word with Interrupt Acceptance Gate

This block holds the 8-bit status word of a small CPU core: interrupt enable, zero, auxiliary carry, carry, a two-bit register-bank number and a two-bit in-service priority level. The core's decode stage drives it with one-cycle strobes for the enable, disable, bank-select, push and restore operations. The ALU stage writes the three arithmetic flags through a single write enable.

Alongside the register, the block decides whether a pending maskable interrupt may be taken. A request is taken only when interrupts are enabled, the source is unmasked and its level is more urgent than the current in-service level. When the core acknowledges an accepted request, the enable flag clears and the in-service level takes the request's level in the same cycle. The word as it stood before that change is presented for stacking. A return or pop reloads the whole word.

Top module: `cpu_status_word`

## Requirements
- R1: While rst_n is low at a clock edge the word becomes 0x06: in-service level 3 (bits 2:1), every other bit 0, bank_sel 0. The bit layout from bit 7 to bit 0 is enable, zero, bank high, aux carry, bank low, level high, level low, carry.
- R2: ei_op sets bit 7 at the next edge and di_op clears it. When both are asserted in the same cycle, the bit is cleared.
- R3: irq_accept is 0 whenever bit 7 of the word is 0, whatever the request, mask and level.
- R4: irq_accept is 0 whenever irq_masked is 1.
- R5: With bit 7 set and the request unmasked, irq_accept is 1 only when irq_level is numerically lower than word bits 2:1; an equal or higher value is refused.
- R6: irq_ack in a cycle where irq_accept is 1 clears bit 7 and loads irq_level into bits 2:1 at the next edge. In that same cycle save_strobe is 1 and save_word shows the unchanged word.
- R7: irq_ack in a cycle where irq_accept is 0 changes nothing in the word.
- R8: flag_we loads bit 6 from res_zero, bit 4 from res_half_carry and bit 0 from res_carry, and leaves the other bits unchanged.
- R9: sel_op loads sel_bank[1] into bit 5 and sel_bank[0] into bit 3; bank_sel always reports {bit 5, bit 3}.
- R10: restore_op loads restore_word into the whole word and overrides every other same-cycle update.
- R11: push_op raises save_strobe and presents the current word on save_word, leaving the word unchanged.
- R12: An accepted acknowledge beats ei_op on bit 7 in the same cycle. Updates to unrelated fields in that cycle still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flag_we | input | 1 | Write ALU flags this cycle |
| res_zero | input | 1 | ALU result was zero |
| res_half_carry | input | 1 | ALU auxiliary carry out |
| res_carry | input | 1 | ALU carry out |
| ei_op | input | 1 | Enable-interrupts operation |
| di_op | input | 1 | Disable-interrupts operation |
| sel_op | input | 1 | Select-bank operation |
| sel_bank | input | 2 | Bank number for sel_op |
| push_op | input | 1 | Push-status operation |
| restore_op | input | 1 | Return or pop: reload the word |
| restore_word | input | 8 | Word popped from the stack |
| irq_req | input | 1 | Maskable interrupt pending |
| irq_level | input | 2 | Priority of the pending request, 0 most urgent |
| irq_masked | input | 1 | Mask flag of the pending source |
| irq_ack | input | 1 | Core acknowledges the interrupt |
| psw | output | 8 | Current status word |
| save_word | output | 8 | Word to be stacked |
| save_strobe | output | 1 | save_word is to be written to the stack |
| bank_sel | output | 2 | Selected register bank |
| irq_accept | output | 1 | Pending request may be taken |

## Verification
The acceptance gate is tried with requests whose level is below, equal to and above the in-service level. This separates a strict comparison from a non-strict one and from an inverted one. Masked and disabled-state requests show that each of the two vetoes works on its own. A nested pair of acknowledges, an acknowledge while refused and a restore that collides with every other update show whether the update priority is applied field by field and whether save_word lags the acknowledge.

// File: rtl/csw_pkg.sv
// Shared layout of the status word.
// Assumes: the bit order is fixed because the stacked image is decoded elsewhere.
package csw_pkg;
    localparam int WORD_W  = 8;
    localparam int LEVEL_W = 2;
    localparam int BANK_W  = 2;

    typedef struct packed {
        logic               ie;
        logic               z;
        logic               bank_hi;
        logic               ac;
        logic               bank_lo;
        logic [LEVEL_W-1:0] isp;
        logic               cy;
    } csw_t;

    localparam csw_t CSW_RESET = csw_t'(8'h06);
endpackage

// File: rtl/csw_gate.sv
// Interrupt acceptance gate: a request passes only when it is enabled,
// unmasked and strictly more urgent than the in-service level.
// Assumes: a lower level value means more urgent.
module csw_gate #(
    parameter int LEVEL_W = 2
) (
    input  logic               ie,
    input  logic [LEVEL_W-1:0] isp,
    input  logic               req,
    input  logic [LEVEL_W-1:0] level,
    input  logic               masked,
    output logic               accept
);
    // Combine the enable, the mask and the level comparison.
    always_comb begin
        accept = req & ie & ~masked & (level < isp);
    end
endmodule

// File: rtl/csw_next.sv
// Next-value logic of the status word. Later assignments override earlier
// ones, field by field: ALU flags, then EI/DI/SEL, then acknowledge, then restore.
// Assumes: ack_take is already qualified by acceptance.
module csw_next
    import csw_pkg::*;
(
    input  csw_t               cur,
    input  logic               flag_we,
    input  logic               res_zero,
    input  logic               res_half_carry,
    input  logic               res_carry,
    input  logic               ei_op,
    input  logic               di_op,
    input  logic               sel_op,
    input  logic [BANK_W-1:0]  sel_bank,
    input  logic               ack_take,
    input  logic [LEVEL_W-1:0] ack_level,
    input  logic               restore_op,
    input  logic [WORD_W-1:0]  restore_word,
    output csw_t               nxt
);
    // Apply the updates from lowest to highest priority.
    always_comb begin
        nxt = cur;
        if (flag_we) begin
            nxt.z  = res_zero;
            nxt.ac = res_half_carry;
            nxt.cy = res_carry;
        end
        if (sel_op) begin
            nxt.bank_hi = sel_bank[1];
            nxt.bank_lo = sel_bank[0];
        end
        if (ei_op) nxt.ie = 1'b1;
        if (di_op) nxt.ie = 1'b0;
        if (ack_take) begin
            nxt.ie  = 1'b0;
            nxt.isp = ack_level;
        end
        if (restore_op) nxt = csw_t'(restore_word);
    end
endmodule

// File: rtl/cpu_status_word.sv
// Status word register with interrupt acceptance.
// Assumes: control strobes last one cycle; the stack write of save_word
// is done by the core when save_strobe is high.
module cpu_status_word
    import csw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flag_we,
    input  logic               res_zero,
    input  logic               res_half_carry,
    input  logic               res_carry,
    input  logic               ei_op,
    input  logic               di_op,
    input  logic               sel_op,
    input  logic [BANK_W-1:0]  sel_bank,
    input  logic               push_op,
    input  logic               restore_op,
    input  logic [WORD_W-1:0]  restore_word,
    input  logic               irq_req,
    input  logic [LEVEL_W-1:0] irq_level,
    input  logic               irq_masked,
    input  logic               irq_ack,
    output logic [WORD_W-1:0]  psw,
    output logic [WORD_W-1:0]  save_word,
    output logic               save_strobe,
    output logic [BANK_W-1:0]  bank_sel,
    output logic               irq_accept
);
    csw_t word_q;
    csw_t word_d;
    logic ack_take;

    csw_gate #(.LEVEL_W(LEVEL_W)) i_gate (
        .ie     (word_q.ie),
        .isp    (word_q.isp),
        .req    (irq_req),
        .level  (irq_level),
        .masked (irq_masked),
        .accept (irq_accept)
    );

    // An acknowledge only counts for a request the gate lets through.
    always_comb ack_take = irq_ack & irq_accept;

    csw_next i_next (
        .cur            (word_q),
        .flag_we        (flag_we),
        .res_zero       (res_zero),
        .res_half_carry (res_half_carry),
        .res_carry      (res_carry),
        .ei_op          (ei_op),
        .di_op          (di_op),
        .sel_op         (sel_op),
        .sel_bank       (sel_bank),
        .ack_take       (ack_take),
        .ack_level      (irq_level),
        .restore_op     (restore_op),
        .restore_word   (restore_word),
        .nxt            (word_d)
    );

    // Hold the status word; reset has the highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= CSW_RESET;
        else        word_q <= word_d;
    end

    // Drive the outputs from the registered word.
    always_comb begin
        psw         = word_q;
        save_word   = word_q;
        save_strobe = push_op | ack_take;
        bank_sel    = {word_q.bank_hi, word_q.bank_lo};
    end
endmodule

// File: rtl/csw_checker.sv
// Temporal checks on the status word ports, bound into every instance.
module csw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ei_op,
    input logic       di_op,
    input logic       sel_op,
    input logic       flag_we,
    input logic       push_op,
    input logic       restore_op,
    input logic [7:0] restore_word,
    input logic [1:0] irq_level,
    input logic       irq_masked,
    input logic       irq_ack,
    input logic [7:0] psw,
    input logic [7:0] save_word,
    input logic       save_strobe,
    input logic       irq_accept
);
    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> psw == 8'h06);

    assert_disabled_refuses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !psw[7] |-> !irq_accept);

    assert_masked_refuses_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_masked |-> !irq_accept);

    assert_level_strict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> irq_level < psw[2:1]);

    assert_ack_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_accept && !restore_op) |=>
            (!psw[7] && psw[2:1] == $past(irq_level)));

    assert_ack_saves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_accept) |-> (save_strobe && save_word == psw));

    assert_restore_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restore_op |=> psw == $past(restore_word));

    assert_push_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_op && !restore_op && !irq_ack && !ei_op && !di_op && !sel_op && !flag_we)
            |=> $stable(psw));
endmodule

bind cpu_status_word csw_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ei_op        (ei_op),
    .di_op        (di_op),
    .sel_op       (sel_op),
    .flag_we      (flag_we),
    .push_op      (push_op),
    .restore_op   (restore_op),
    .restore_word (restore_word),
    .irq_level    (irq_level),
    .irq_masked   (irq_masked),
    .irq_ack      (irq_ack),
    .psw          (psw),
    .save_word    (save_word),
    .save_strobe  (save_strobe),
    .irq_accept   (irq_accept)
);

// File: tb/test_cpu_status_word.sv
// Directed bench: one task per scenario, each checking its own results.
module test_cpu_status_word;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flag_we = 0, res_zero = 0, res_half_carry = 0, res_carry = 0;
    logic       ei_op = 0, di_op = 0, sel_op = 0, push_op = 0, restore_op = 0;
    logic [1:0] sel_bank = 0;
    logic [7:0] restore_word = 0;
    logic       irq_req = 0, irq_masked = 0, irq_ack = 0;
    logic [1:0] irq_level = 0;
    logic [7:0] psw, save_word;
    logic       save_strobe, irq_accept;
    logic [1:0] bank_sel;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_status_word i_cpu_status_word (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .res_zero(res_zero),
        .res_half_carry(res_half_carry), .res_carry(res_carry),
        .ei_op(ei_op), .di_op(di_op), .sel_op(sel_op), .sel_bank(sel_bank),
        .push_op(push_op), .restore_op(restore_op), .restore_word(restore_word),
        .irq_req(irq_req), .irq_level(irq_level), .irq_masked(irq_masked),
        .irq_ack(irq_ack), .psw(psw), .save_word(save_word),
        .save_strobe(save_strobe), .bank_sel(bank_sel), .irq_accept(irq_accept)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        flag_we = 0; ei_op = 0; di_op = 0; sel_op = 0; push_op = 0;
        restore_op = 0; irq_ack = 0; irq_req = 0; irq_masked = 0;
    endtask

    // Clock edge, then settle in the low phase.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic load(input logic [7:0] w);
        restore_op = 1; restore_word = w;
        step();
    endtask

    task automatic t_reset();
        irq_req = 1; irq_level = 0;
        #1;
        check("R1 reset word", psw, 8'h06);
        check("R1 reset bank", {6'd0, bank_sel}, 8'h00);
        check("R3 accept while disabled", {7'd0, irq_accept}, 8'h00);
        idle();
    endtask

    task automatic t_ei_di();
        ei_op = 1; step();
        check("R2 EI sets enable", psw, 8'h86);
        di_op = 1; step();
        check("R2 DI clears enable", psw, 8'h06);
        ei_op = 1; step();
        ei_op = 1; di_op = 1; step();
        check("R2 DI wins over EI", psw, 8'h06);
    endtask

    task automatic t_masked();
        ei_op = 1; step();
        irq_req = 1; irq_level = 0; irq_masked = 1; #1;
        check("R4 masked refused", {7'd0, irq_accept}, 8'h00);
        irq_masked = 0; #1;
        check("R5 unmasked urgent accepted", {7'd0, irq_accept}, 8'h01);
        idle();
    endtask

    task automatic t_priority();
        load(8'h82);
        check("R10 restore loads word", psw, 8'h82);
        irq_req = 1; irq_level = 1; #1;
        check("R5 equal level refused", {7'd0, irq_accept}, 8'h00);
        irq_level = 2; #1;
        check("R5 lower urgency refused", {7'd0, irq_accept}, 8'h00);
        irq_level = 0; #1;
        check("R5 more urgent accepted", {7'd0, irq_accept}, 8'h01);
        irq_level = 3; load(8'h86); irq_req = 1; irq_level = 3; #1;
        check("R5 level 3 at level 3 refused", {7'd0, irq_accept}, 8'h00);
        idle();
    endtask

    task automatic t_nested();
        load(8'h86);
        irq_req = 1; irq_level = 2; irq_ack = 1; #1;
        check("R6 save strobe on ack", {7'd0, save_strobe}, 8'h01);
        check("R6 save shows old word", save_word, 8'h86);
        step();
        check("R6 ack clears enable, loads level", psw, 8'h04);
        ei_op = 1; step();
        irq_req = 1; irq_level = 1; irq_ack = 1; step();
        check("R6 nested ack", psw, 8'h02);
        irq_req = 1; irq_level = 0; irq_ack = 1; #1;
        check("R7 no strobe on refused ack", {7'd0, save_strobe}, 8'h00);
        step();
        check("R7 refused ack ignored", psw, 8'h02);
        load(8'h84);
        check("R10 return restores", psw, 8'h84);
    endtask

    task automatic t_flags();
        flag_we = 1; res_zero = 1; res_half_carry = 1; res_carry = 1; step();
        check("R8 flags set", psw, 8'hD5);
        flag_we = 1; res_zero = 0; res_half_carry = 0; res_carry = 1; step();
        check("R8 flags mixed", psw, 8'h85);
    endtask

    task automatic t_bank();
        sel_op = 1; sel_bank = 2'd2; step();
        check("R9 bank 2 word", psw, 8'hA5);
        check("R9 bank 2 out", {6'd0, bank_sel}, 8'h02);
        sel_op = 1; sel_bank = 2'd1; step();
        check("R9 bank 1 word", psw, 8'h8D);
        check("R9 bank 1 out", {6'd0, bank_sel}, 8'h01);
    endtask

    task automatic t_push();
        push_op = 1; #1;
        check("R11 push strobe", {7'd0, save_strobe}, 8'h01);
        check("R11 push value", save_word, 8'h8D);
        step();
        check("R11 push keeps word", psw, 8'h8D);
    endtask

    task automatic t_conflict();
        restore_op = 1; restore_word = 8'h06; ei_op = 1; sel_op = 1; sel_bank = 2'd3;
        flag_we = 1; res_zero = 1; res_half_carry = 1; res_carry = 1;
        step();
        check("R10 restore overrides all", psw, 8'h06);
        ei_op = 1; step();
        irq_req = 1; irq_level = 0; irq_ack = 1; ei_op = 1; sel_op = 1; sel_bank = 2'd3;
        step();
        check("R12 ack beats EI, bank applies", psw, 8'h28);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_ei_di();
        t_masked();
        t_priority();
        t_nested();
        t_flags();
        t_bank();
        t_push();
        t_conflict();
        rst_n = 1'b0; step();
        check("R1 reset again", psw, 8'h06);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule